// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block is the segmentation stage of an address path. It takes a logical address made of a 16-bit selector and a 32-bit offset, together with an access type (read, write or execute). From these it produces either a 32-bit linear address or a fault code. The selector is split into an entry index, a bit that chooses the global or the local descriptor table, and a requested privilege field. The unit then checks the index against the chosen table's entry count and fetches the 8-byte descriptor through a read port. It tests the descriptor for validity, segment limit, access rights and privilege, and finally adds the segment base to the offset.

Each table has its own base-address and entry-count inputs. These are held by whatever loads the address context, and the unit samples them when it accepts a request. The unit handles one translation at a time. A request is taken while `req_ready` is high. The answer comes back as a single-cycle `resp_valid` pulse. Descriptor reads may take any number of cycles, from one upward.

Top module: `seg_xlat_unit`

## Requirements
- R1: The selector is decoded as entry index = bits [15:3], table choice = bit 2 (0 global, 1 local) and requested privilege = bits [1:0]; the table choice selects which base/count pair is used for both the bound check and the descriptor fetch.
- R2: For an in-range request exactly one descriptor read is issued, a one-cycle `desc_rd_req` pulse whose address is the chosen table base plus eight times the entry index.
- R3: An index not less than the chosen table's entry count gives fault code 1; no descriptor read is issued, and the response appears in the cycle after acceptance.
- R4: A descriptor whose valid bit (data bit 69) is 0 gives fault code 2.
- R5: An offset not less than the descriptor limit (data bits [63:32]) gives fault code 3; a zero limit rejects every offset.
- R6: Access type 0 (read) needs the read right (bit 68), 1 (write) the write right (bit 67), and 2 (execute) the execute right (bit 66); access type 3 always fails. A failed right gives fault code 4.
- R7: A requested privilege numerically greater than the descriptor privilege (bits [65:64]) gives fault code 5.
- R8: When several checks fail, the reported code is the lowest of them: range, then invalid, then limit, then rights, then privilege.
- R9: With no fault the result is fault code 0 and linear address = descriptor base (bits [31:0]) + offset, modulo 2^32; on any fault the linear address is 0.
- R10: After reset, and between transactions, `req_ready` is 1 and `resp_valid` and `desc_rd_req` are 0. `req_ready` is 0 while a translation is in flight, and `resp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| glob_tbl_base | input | 32 | Start address of the global descriptor table |
| glob_tbl_len | input | 14 | Number of entries in the global table |
| loc_tbl_base | input | 32 | Start address of the local descriptor table |
| loc_tbl_len | input | 14 | Number of entries in the local table |
| desc_rd_req | output | 1 | Descriptor read strobe |
| desc_rd_addr | output | 32 | Descriptor read address |
| desc_rd_valid | input | 1 | Descriptor data returned |
| desc_rd_data | input | 70 | Descriptor: valid, read, write, execute, privilege, limit, base |
| resp_valid | output | 1 | Result present for one cycle |
| resp_fault | output | 3 | 0 none, 1 range, 2 invalid, 3 limit, 4 rights, 5 privilege |
| resp_lin | output | 32 | Linear address, 0 on a fault |

## Verification
A table of selectors is sent against a known set of global and local descriptors. The same index is used in both tables, which shows that the table bit steers both the bound check and the read address. Offsets are placed one below, at, and past each limit, and a base near the top of the space shows that the sum wraps. Descriptors are built so that two or three checks fail at once, which separates the priority order. All four access codes are tried against each rights combination. Directed cases cover an empty local table and the largest index of a full global table, and the descriptor read latency is varied between one and three cycles.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int SEL_W       = 16;
    localparam int IDX_W       = 13;
    localparam int PRIV_W      = 2;
    localparam int ADDR_W      = 32;
    localparam int LEN_W       = IDX_W + 1;
    localparam int ENTRY_SHIFT = 3;
    localparam int DESC_W      = 4 + PRIV_W + 2 * ADDR_W;
    localparam int NCHK        = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_RIGHTS  = 3'd4,
        FLT_PRIV    = 3'd5
    } fault_e;

    typedef struct packed {
        logic              valid;
        logic              rd_ok;
        logic              wr_ok;
        logic              ex_ok;
        logic [PRIV_W-1:0] dpl;
        logic [ADDR_W-1:0] limit;
        logic [ADDR_W-1:0] base;
    } desc_t;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              local_tbl;
        logic [PRIV_W-1:0] rpl;
    } sel_fields_t;

    function automatic sel_fields_t split_sel(input logic [SEL_W-1:0] sel);
        sel_fields_t f;
        f.idx       = sel[SEL_W-1 -: IDX_W];
        f.local_tbl = sel[PRIV_W];
        f.rpl       = sel[PRIV_W-1:0];
        return f;
    endfunction

    function automatic logic rights_ok(input desc_t d, input acc_e a);
        logic ok;
        case (a)
            ACC_READ:  ok = d.rd_ok;
            ACC_WRITE: ok = d.wr_ok;
            ACC_EXEC:  ok = d.ex_ok;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_xlat_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] glob_base,
    input  logic [LEN_W-1:0]  glob_len,
    input  logic [ADDR_W-1:0] loc_base,
    input  logic [LEN_W-1:0]  loc_len,
    output sel_fields_t       fields,
    output logic              in_range,
    output logic [ADDR_W-1:0] entry_addr
);
    logic [ADDR_W-1:0] tbl_base;
    logic [LEN_W-1:0]  tbl_len;

    always_comb begin
        fields     = split_sel(sel);
        tbl_base   = fields.local_tbl ? loc_base : glob_base;
        tbl_len    = fields.local_tbl ? loc_len  : glob_len;
        in_range   = {1'b0, fields.idx} < tbl_len;
        entry_addr = tbl_base + (ADDR_W'(fields.idx) << ENTRY_SHIFT);
    end

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_xlat_pkg::*;
(
    input  desc_t             desc,
    input  logic [ADDR_W-1:0] off,
    input  acc_e              acc,
    input  logic [PRIV_W-1:0] rpl,
    output fault_e            fault,
    output logic [ADDR_W-1:0] lin
);
    // failing checks, index 0 has the highest priority
    logic [NCHK-1:0] hit;

    always_comb begin
        hit[0] = !desc.valid;
        hit[1] = off >= desc.limit;
        hit[2] = !rights_ok(desc, acc);
        hit[3] = rpl > desc.dpl;
    end

    always_comb begin
        fault = FLT_NONE;
        for (int i = NCHK - 1; i >= 0; i--) begin
            if (hit[i]) fault = fault_e'(3'(i + 2));
        end
        lin = (fault == FLT_NONE) ? desc.base + off : '0;
    end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_off,
    input  logic [1:0]        req_acc,
    input  logic [ADDR_W-1:0] glob_tbl_base,
    input  logic [LEN_W-1:0]  glob_tbl_len,
    input  logic [ADDR_W-1:0] loc_tbl_base,
    input  logic [LEN_W-1:0]  loc_tbl_len,
    output logic              desc_rd_req,
    output logic [ADDR_W-1:0] desc_rd_addr,
    input  logic              desc_rd_valid,
    input  logic [DESC_W-1:0] desc_rd_data,
    output logic              resp_valid,
    output logic [2:0]        resp_fault,
    output logic [ADDR_W-1:0] resp_lin
);
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} st_e;

    st_e               st;
    sel_fields_t       dec_fields;
    logic              dec_in_range;
    logic [ADDR_W-1:0] dec_addr;
    fault_e            chk_fault;
    logic [ADDR_W-1:0] chk_lin;

    logic [PRIV_W-1:0] rpl_q;
    logic [ADDR_W-1:0] off_q;
    acc_e              acc_q;
    logic [ADDR_W-1:0] addr_q;
    fault_e            fault_q;
    logic [ADDR_W-1:0] lin_q;

    seg_sel_decode u_dec (
        .sel        (req_sel),
        .glob_base  (glob_tbl_base),
        .glob_len   (glob_tbl_len),
        .loc_base   (loc_tbl_base),
        .loc_len    (loc_tbl_len),
        .fields     (dec_fields),
        .in_range   (dec_in_range),
        .entry_addr (dec_addr)
    );

    seg_desc_check u_chk (
        .desc  (desc_t'(desc_rd_data)),
        .off   (off_q),
        .acc   (acc_q),
        .rpl   (rpl_q),
        .fault (chk_fault),
        .lin   (chk_lin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rpl_q   <= '0;
            off_q   <= '0;
            acc_q   <= ACC_READ;
            addr_q  <= '0;
            fault_q <= FLT_NONE;
            lin_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        rpl_q  <= dec_fields.rpl;
                        off_q  <= req_off;
                        acc_q  <= acc_e'(req_acc);
                        addr_q <= dec_addr;
                        lin_q  <= '0;
                        if (dec_in_range) begin
                            fault_q <= FLT_NONE;
                            st      <= ST_FETCH;
                        end else begin
                            fault_q <= FLT_RANGE;
                            st      <= ST_RESP;
                        end
                    end
                end
                ST_FETCH: st <= ST_WAIT;
                ST_WAIT: begin
                    if (desc_rd_valid) begin
                        fault_q <= chk_fault;
                        lin_q   <= chk_lin;
                        st      <= ST_RESP;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st == ST_IDLE);
    assign desc_rd_req  = (st == ST_FETCH);
    assign desc_rd_addr = addr_q;
    assign resp_valid   = (st == ST_RESP);
    assign resp_fault   = fault_q;
    assign resp_lin     = lin_q;

endmodule

// File: rtl/seg_xlat_unit_chk.sv
module seg_xlat_unit_chk
    import seg_xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              desc_rd_req,
    input logic              resp_valid,
    input logic [2:0]        resp_fault,
    input logic [ADDR_W-1:0] resp_lin
);
    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R10
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_rd_req || resp_valid) |-> !req_ready);

    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        desc_rd_req |=> !desc_rd_req);

    // R9
    fault_lin_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault != 3'd0) |-> resp_lin == '0);

    // R8
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> resp_fault <= 3'd5);

    // R3
    range_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault == 3'd1) |-> !$past(desc_rd_req));

endmodule

bind seg_xlat_unit seg_xlat_unit_chk u_chk_bind (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .desc_rd_req (desc_rd_req),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_lin    (resp_lin)
);

// File: tb/sim_seg_xlat_unit.sv
module sim_seg_xlat_unit;
    import seg_xlat_pkg::*;

    localparam logic [31:0] GB = 32'h0001_0000;
    localparam logic [31:0] LB = 32'h0010_0000;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [15:0]       req_sel;
    logic [31:0]       req_off;
    logic [1:0]        req_acc;
    logic [31:0]       glob_tbl_base, loc_tbl_base;
    logic [13:0]       glob_tbl_len, loc_tbl_len;
    logic              desc_rd_req;
    logic [31:0]       desc_rd_addr;
    logic              desc_rd_valid;
    logic [69:0]       desc_rd_data;
    logic              resp_valid;
    logic [2:0]        resp_fault;
    logic [31:0]       resp_lin;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    int lat = 1;
    bit done = 0;
    logic [31:0] last_addr = '0;

    always #4 clk = ~clk;

    seg_xlat_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_off(req_off), .req_acc(req_acc),
        .glob_tbl_base(glob_tbl_base), .glob_tbl_len(glob_tbl_len),
        .loc_tbl_base(loc_tbl_base), .loc_tbl_len(loc_tbl_len),
        .desc_rd_req(desc_rd_req), .desc_rd_addr(desc_rd_addr),
        .desc_rd_valid(desc_rd_valid), .desc_rd_data(desc_rd_data),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_lin(resp_lin)
    );

    function automatic desc_t mk(input logic v, r, w, x, input logic [1:0] p,
                                 input logic [31:0] lim, input logic [31:0] b);
        desc_t d;
        d.valid = v; d.rd_ok = r; d.wr_ok = w; d.ex_ok = x;
        d.dpl = p; d.limit = lim; d.base = b;
        return d;
    endfunction

    function automatic desc_t ref_desc(input logic tbl, input logic [12:0] idx);
        desc_t d = '0;
        if (!tbl) begin
            case (idx)
                13'd0: d = mk(1, 1, 1, 0, 2'd3, 32'h100,  32'h0001_0000);
                13'd1: d = mk(1, 1, 0, 1, 2'd0, 32'h1000, 32'h0020_0000);
                13'd2: d = mk(0, 1, 1, 1, 2'd3, 32'h0,    32'h0090_0000);
                13'd3: d = mk(1, 1, 0, 0, 2'd2, 32'h200,  32'hFFFF_FF00);
                default: d = '0;
            endcase
        end else begin
            case (idx)
                13'd0: d = mk(1, 1, 1, 0, 2'd3, 32'h40, 32'h0300_0000);
                13'd1: d = mk(1, 0, 0, 1, 2'd1, 32'h10, 32'h0400_0000);
                13'd2: d = mk(1, 1, 1, 0, 2'd3, 32'h0,  32'h0500_0000);
                default: d = '0;
            endcase
        end
        return d;
    endfunction

    function automatic desc_t model(input logic [31:0] a);
        if (a >= GB && a < GB + 32'h1_0000) return ref_desc(1'b0, 13'((a - GB) >> 3));
        if (a >= LB && a < LB + 32'h1_0000) return ref_desc(1'b1, 13'((a - LB) >> 3));
        return '0;
    endfunction

    // descriptor store with latency cycling 1..3
    initial begin
        desc_rd_valid = 1'b0;
        desc_rd_data  = '0;
        forever begin
            @(negedge clk);
            if (desc_rd_req) begin
                logic [31:0] a;
                a = desc_rd_addr;
                rd_count++;
                last_addr = a;
                repeat (lat) @(negedge clk);
                desc_rd_data  = model(a);
                desc_rd_valid = 1'b1;
                @(negedge clk);
                desc_rd_valid = 1'b0;
                lat = (lat == 3) ? 1 : lat + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xlat(input logic tbl, input logic [12:0] idx, input logic [1:0] rpl,
                        input logic [31:0] off, input logic [1:0] acc, input logic [2:0] ef,
                        input string tag);
        int n0;
        int w;
        desc_t d;
        logic [31:0] el;
        logic [31:0] ea;
        d  = ref_desc(tbl, idx);
        el = (ef == 3'd0) ? d.base + off : 32'h0;
        ea = (tbl ? loc_tbl_base : glob_tbl_base) + {16'h0, idx, 3'b000};
        n0 = rd_count;
        @(negedge clk);
        req_sel = {idx, tbl, rpl}; req_off = off; req_acc = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {"R10 busy ", tag}, 32'(req_ready), 32'h0);
        w = 0;
        while (!resp_valid && w < 60) begin
            @(negedge clk);
            w++;
        end
        chk(resp_valid == 1'b1, {"R10 response ", tag}, 32'(resp_valid), 32'h1);
        chk(resp_fault == ef, {"R8 fault ", tag}, 32'(resp_fault), 32'(ef));
        chk(resp_lin == el, {"R9 linear ", tag}, resp_lin, el);
        if (ef == 3'd1) begin
            chk(w == 0, {"R3 latency ", tag}, 32'(w), 32'h0);
            chk(rd_count == n0, {"R3 no read ", tag}, 32'(rd_count - n0), 32'h0);
        end else begin
            chk(rd_count == n0 + 1, {"R2 one read ", tag}, 32'(rd_count - n0), 32'h1);
            chk(last_addr == ea, {"R2 R1 address ", tag}, last_addr, ea);
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, {"R10 pulse ", tag}, 32'(resp_valid), 32'h0);
    endtask

    typedef struct packed {
        logic        tbl;
        logic [12:0] idx;
        logic [1:0]  rpl;
        logic [31:0] off;
        logic [1:0]  acc;
        logic [2:0]  flt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 13'd0, 2'd3, 32'h10,   2'd0, 3'd0}, // R9 R1 read ok
        '{1'b0, 13'd0, 2'd0, 32'hFF,   2'd1, 3'd0}, // R5 last byte
        '{1'b0, 13'd0, 2'd3, 32'h100,  2'd0, 3'd3}, // R5 at limit
        '{1'b0, 13'd0, 2'd3, 32'h0,    2'd2, 3'd4}, // R6 no exec
        '{1'b0, 13'd1, 2'd0, 32'hFFF,  2'd2, 3'd0}, // R6 exec ok
        '{1'b0, 13'd1, 2'd0, 32'h0,    2'd1, 3'd4}, // R6 no write
        '{1'b0, 13'd1, 2'd1, 32'h0,    2'd0, 3'd5}, // R7 privilege
        '{1'b0, 13'd2, 2'd0, 32'h5,    2'd0, 3'd2}, // R4 R8 invalid over limit
        '{1'b0, 13'd3, 2'd2, 32'h1F0,  2'd0, 3'd0}, // R9 wrap
        '{1'b0, 13'd4, 2'd0, 32'h0,    2'd0, 3'd1}, // R3 global bound
        '{1'b1, 13'd0, 2'd3, 32'h3F,   2'd1, 3'd0}, // R1 local table
        '{1'b1, 13'd1, 2'd1, 32'h8,    2'd2, 3'd0}, // R6 exec only
        '{1'b1, 13'd1, 2'd1, 32'h10,   2'd0, 3'd3}, // R8 limit over rights
        '{1'b1, 13'd2, 2'd3, 32'h0,    2'd0, 3'd3}, // R5 zero limit
        '{1'b1, 13'd3, 2'd0, 32'h0,    2'd0, 3'd1}, // R3 local bound
        '{1'b1, 13'd0, 2'd3, 32'h0,    2'd3, 3'd4}, // R6 reserved access
        '{1'b0, 13'd1, 2'd3, 32'h2000, 2'd1, 3'd3}, // R8 limit over rights and privilege
        '{1'b1, 13'd1, 2'd2, 32'h0,    2'd2, 3'd5}  // R7 local privilege
    };

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_sel = '0; req_off = '0; req_acc = '0;
        glob_tbl_base = GB; glob_tbl_len = 14'd4;
        loc_tbl_base  = LB; loc_tbl_len  = 14'd3;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'h1);
        chk(resp_valid == 1'b0, "R10 reset resp", 32'(resp_valid), 32'h0);
        chk(desc_rd_req == 1'b0, "R10 reset read", 32'(desc_rd_req), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 idle ready", 32'(req_ready), 32'h1);

        for (int i = 0; i < NV; i++) begin
            xlat(VECS[i].tbl, VECS[i].idx, VECS[i].rpl, VECS[i].off,
                 VECS[i].acc, VECS[i].flt, $sformatf("vec%0d", i));
        end

        // R3 empty local table rejects index 0
        loc_tbl_len = 14'd0;
        xlat(1'b1, 13'd0, 2'd3, 32'h0, 2'd0, 3'd1, "empty local");
        loc_tbl_len = 14'd3;
        // R2 largest index of a full global table, entry unpopulated -> R4
        glob_tbl_len = 14'd8192;
        xlat(1'b0, 13'd8191, 2'd0, 32'h0, 2'd0, 3'd2, "top index");
        glob_tbl_len = 14'd4;
        // R1 same index in both tables differs only by table bit
        xlat(1'b0, 13'd0, 2'd3, 32'h3F, 2'd0, 3'd0, "global idx0");
        xlat(1'b1, 13'd0, 2'd3, 32'h3F, 2'd0, 3'd0, "local idx0");

        @(negedge clk);
        chk(req_ready == 1'b1, "R10 back to idle", 32'(req_ready), 32'h1);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule